// File: doc/BRIEF.md
# Frequency-Compensated Precision Time Counter

This block keeps a 64-bit nanosecond time-of-day value for packet timestamping. It runs from a fast reference clock domain. A selectable reference enable marks the cycles that count. On each such cycle a 32-bit fractional accumulator adds a software-trimmed addend. Every accumulator carry is one nominal tick, and each tick advances the time value by the programmed tick period in nanoseconds. Software can trim the rate in parts per billion by changing the addend. The accumulator is never cleared when it does so.

The nominal ticks drive two further functions. A prescaler makes an output-clock strobe. Two independent period-pulse generators each hold a nanosecond down-counter. A period value is programmed as the wanted interval minus one tick, so a value of one second minus one tick gives one pulse per second. A global pulse enable holds both generators idle until software has set them up. The choice of reference is modelled as a selection among four enable inputs. The code picks the enable, and when no valid code is given the system clock enable is used.

Top module: `ptp_timer_core`

## Requirements
- R1: While reset is high, and in the first sample after it, `time_ns` is 0 and `out_clk`, `pulse1` and `pulse2` are low.
- R2: Every counted cycle adds `addend` to a 32-bit accumulator modulo 2^32, and each carry out advances `time_ns` by `tick_period`, modulo 2^64. After counted cycles whose addends sum to S, counted from reset, `time_ns` equals floor(S / 2^32) × `tick_period`. This holds when the addend changes mid-run.
- R3: With `src_sel_vld` high, `src_sel` codes 0, 1, 2 and 3 make `ref_en` bits 0 (external precision clock), 1 (system clock), 2 (transmit clock) and 3 (RTC input) the counted enable. With `src_sel_vld` low, bit 1 is used.
- R4: In a cycle where the selected enable is low, `time_ns` does not change.
- R5: `out_clk` is a strobe that lasts one nominal tick and occurs every `prescale` ticks (values 0 and 1 both mean every tick). After T ticks from reset it has risen floor(T / `prescale`) times when `prescale` ≥ 2.
- R6: Each pulse generator loads its period at reset or while disabled. On each tick it subtracts `tick_period`. On the tick where the remaining count is below `tick_period` it pulses high for one tick and reloads. Consecutive rises are therefore (floor(period / `tick_period`) + 1) × `tick_period` ns of `time_ns` apart.
- R7: The two generators are independent. A period of 10^9 − `tick_period` gives exactly 10^9 ns between consecutive `pulse1` rises.
- R8: While `pulse_en` is low, `pulse1` and `pulse2` stay low and their counters are held at their periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 4 | Per-source count enables |
| src_sel | input | 2 | Reference source code |
| src_sel_vld | input | 1 | Source code valid; low selects the system clock |
| pulse_en | input | 1 | Global enable for both pulse generators |
| tick_period | input | TP_W | Nanoseconds added per nominal tick |
| addend | input | ACC_W | Accumulator addend (rate trim) |
| prescale | input | PSC_W | Ticks per output-clock strobe |
| period1 | input | PER_W | Pulse 1 period, interval minus one tick, in ns |
| period2 | input | PER_W | Pulse 2 period, interval minus one tick, in ns |
| time_ns | output | TIME_W | Running nanosecond count |
| out_clk | output | 1 | Prescaled output-clock strobe |
| pulse1 | output | 1 | Fixed-interval pulse 1 |
| pulse2 | output | 1 | Fixed-interval pulse 2 |

## Verification
The bench builds the core with its default widths: a 64-bit time value, a 32-bit accumulator, 20-bit tick periods and 32-bit pulse periods. The 20-bit tick field allows a 100 µs tick. That puts a full one-second interval between two `pulse1` rises within about 16,000 reference cycles per pulse, so the 1e9 ns spacing is checked exactly. With the reference 10 ns settings, the second generator's 100 µs interval and the long-run tick rate are checked against the exact floor of the summed addends.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_SYS = 2'd1,
    SRC_TXC = 2'd2,
    SRC_RTC = 2'd3
  } ref_src_e;

  localparam int unsigned NUM_SRC   = 4;
  localparam int unsigned NUM_PULSE = 2;
endpackage

// File: rtl/ptp_time_base.sv
module ptp_time_base #(
  parameter int TIME_W = 64,
  parameter int ACC_W  = 32,
  parameter int TP_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [ACC_W-1:0]  addend,
  input  logic [TP_W-1:0]   tick_period,
  output logic [TIME_W-1:0] time_ns,
  output logic              tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      tick    <= 1'b0;
      time_ns <= '0;
    end else begin
      tick <= step & sum[ACC_W];
      if (step) begin
        acc <= sum[ACC_W-1:0];
        if (sum[ACC_W]) time_ns <= time_ns + TIME_W'(tick_period);
      end
    end
  end
endmodule

// File: rtl/ptp_out_div.sv
module ptp_out_div #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PSC_W-1:0] prescale,
  output logic             strobe
);
  logic [PSC_W-1:0] cnt;
  logic [PSC_W-1:0] last;

  assign last = (prescale == '0) ? '0 : prescale - PSC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (tick) begin
      if (cnt >= last) begin
        cnt    <= '0;
        strobe <= 1'b1;
      end else begin
        cnt    <= cnt + PSC_W'(1);
        strobe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptp_period_pulse.sv
module ptp_period_pulse #(
  parameter int PER_W = 32,
  parameter int TP_W  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [TP_W-1:0]  tick_period,
  input  logic [PER_W-1:0] period,
  output logic             pulse
);
  logic [PER_W-1:0] remain;
  logic [PER_W-1:0] tp_ext;

  assign tp_ext = PER_W'(tick_period);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      remain <= period;
      pulse  <= 1'b0;
    end else if (tick) begin
      if (remain < tp_ext) begin
        remain <= period;
        pulse  <= 1'b1;
      end else begin
        remain <= remain - tp_ext;
        pulse  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptp_timer_core.sv
module ptp_timer_core import ptp_pkg::*; #(
  parameter int TIME_W = 64,
  parameter int ACC_W  = 32,
  parameter int TP_W   = 20,
  parameter int PSC_W  = 16,
  parameter int PER_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ref_en,
  input  logic [1:0]         src_sel,
  input  logic               src_sel_vld,
  input  logic               pulse_en,
  input  logic [TP_W-1:0]    tick_period,
  input  logic [ACC_W-1:0]   addend,
  input  logic [PSC_W-1:0]   prescale,
  input  logic [PER_W-1:0]   period1,
  input  logic [PER_W-1:0]   period2,
  output logic [TIME_W-1:0]  time_ns,
  output logic               out_clk,
  output logic               pulse1,
  output logic               pulse2
);
  ref_src_e               src;
  logic                   step;
  logic                   tick;
  logic [PER_W-1:0]       per_arr [NUM_PULSE];
  logic [NUM_PULSE-1:0]   pls;

  assign src  = src_sel_vld ? ref_src_e'(src_sel) : SRC_SYS;
  assign step = ref_en[src];

  ptp_time_base #(.TIME_W(TIME_W), .ACC_W(ACC_W), .TP_W(TP_W)) u_base (
    .clk(clk), .rst(rst), .step(step), .addend(addend),
    .tick_period(tick_period), .time_ns(time_ns), .tick(tick)
  );

  ptp_out_div #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .prescale(prescale), .strobe(out_clk)
  );

  assign per_arr[0] = period1;
  assign per_arr[1] = period2;

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    ptp_period_pulse #(.PER_W(PER_W), .TP_W(TP_W)) u_pp (
      .clk(clk), .rst(rst), .tick(tick), .en(pulse_en),
      .tick_period(tick_period), .period(per_arr[g]), .pulse(pls[g])
    );
  end

  assign pulse1 = pls[0];
  assign pulse2 = pls[1];
endmodule

// File: rtl/ptp_timer_chk.sv
module ptp_timer_chk #(
  parameter int TIME_W = 64,
  parameter int TP_W   = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        ref_en,
  input logic [1:0]        src_sel,
  input logic              src_sel_vld,
  input logic              pulse_en,
  input logic [TP_W-1:0]   tick_period,
  input logic [TIME_W-1:0] time_ns,
  input logic              out_clk,
  input logic              pulse1,
  input logic              pulse2
);
  logic sel_en;
  assign sel_en = src_sel_vld ? ref_en[src_sel] : ref_en[1];

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (time_ns != $past(time_ns)) |-> (time_ns == $past(time_ns) + TIME_W'($past(tick_period))));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !sel_en |=> $stable(time_ns));

  assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !pulse_en |=> (!pulse1 && !pulse2));

  assert_p1_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse1) |-> ($past(time_ns) != $past(time_ns, 2)));

  assert_p2_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse2) |-> ($past(time_ns) != $past(time_ns, 2)));

  assert_div_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_clk) |-> ($past(time_ns) != $past(time_ns, 2)));
endmodule

bind ptp_timer_core ptp_timer_chk #(.TIME_W(TIME_W), .TP_W(TP_W)) u_chk (
  .clk(clk), .rst(rst), .ref_en(ref_en), .src_sel(src_sel),
  .src_sel_vld(src_sel_vld), .pulse_en(pulse_en), .tick_period(tick_period),
  .time_ns(time_ns), .out_clk(out_clk), .pulse1(pulse1), .pulse2(pulse2)
);

// File: tb/sim_ptp_timer_core.sv
module sim_ptp_timer_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ref_en = 4'h0;
  logic [1:0]  src_sel = 2'd1;
  logic        src_sel_vld = 1'b1;
  logic        pulse_en = 1'b0;
  logic [19:0] tick_period = 20'd10;
  logic [31:0] addend = 32'h0;
  logic [15:0] prescale = 16'd100;
  logic [31:0] period1 = 32'h0;
  logic [31:0] period2 = 32'h0;
  logic [63:0] time_ns;
  logic        out_clk, pulse1, pulse2;

  int checks = 0;
  int errors = 0;

  longint unsigned sum, prev_time, lt1, lt2, exp_iv1, exp_iv2;
  bit have1, have2, pp1, pp2, pclk;
  int r1, r2, rclk, hi_cnt;

  always #5 clk = ~clk;

  ptp_timer_core u0 (
    .clk(clk), .rst(rst), .ref_en(ref_en), .src_sel(src_sel),
    .src_sel_vld(src_sel_vld), .pulse_en(pulse_en), .tick_period(tick_period),
    .addend(addend), .prescale(prescale), .period1(period1), .period2(period2),
    .time_ns(time_ns), .out_clk(out_clk), .pulse1(pulse1), .pulse2(pulse2)
  );

  task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit sel_now();
    return src_sel_vld ? ref_en[src_sel] : ref_en[1];
  endfunction

  function automatic longint unsigned ticks_now();
    return sum >> 32;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(time_ns == 64'd0, "R1", time_ns, 0);
    chk({out_clk, pulse1, pulse2} == 3'b000, "R1", {out_clk, pulse1, pulse2}, 0);
    rst = 1'b0;
    sum = 0; prev_time = 0; lt1 = 0; lt2 = 0;
    have1 = 0; have2 = 0; pp1 = 0; pp2 = 0; pclk = 0;
    r1 = 0; r2 = 0; rclk = 0; hi_cnt = 0;
  endtask

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      bit se;
      if (rnd) begin
        ref_en = 4'($urandom);
        if (i % 64 == 0) begin
          src_sel     = 2'($urandom);
          src_sel_vld = ($urandom % 4) != 0;
        end
        if (i % 500 == 0) addend = (i == 0) ? 32'h0 : $urandom;
      end
      se = sel_now();
      @(posedge clk);
      @(negedge clk);
      if (se) sum += addend;
      chk(time_ns == ticks_now() * tick_period, rnd ? "R3" : "R2",
          time_ns, ticks_now() * tick_period);
      if (rnd && !se) chk(time_ns == prev_time, "R4", time_ns, prev_time);
      if (pulse1 && !pp1) begin
        r1++;
        if (have1 && exp_iv1 != 0) chk(prev_time - lt1 == exp_iv1, "R7", prev_time - lt1, exp_iv1);
        lt1 = prev_time; have1 = 1;
      end
      if (pulse2 && !pp2) begin
        r2++;
        if (have2 && exp_iv2 != 0) chk(prev_time - lt2 == exp_iv2, "R6", prev_time - lt2, exp_iv2);
        lt2 = prev_time; have2 = 1;
      end
      if (out_clk && !pclk) rclk++;
      if (pulse1 || pulse2) hi_cnt++;
      pp1 = pulse1; pp2 = pulse2; pclk = out_clk;
      prev_time = time_ns;
    end
  endtask

  task automatic drain();
    ref_en = 4'h0;
    run(4, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Reference settings: 10 ns tick, prescale 100, second pulse every 100 us.
    tick_period = 20'd10; addend = 32'h999999A4; prescale = 16'd100;
    period1 = 32'h3B9AC9F6; period2 = 32'h00018696;
    pulse_en = 1'b1; src_sel = 2'd1; src_sel_vld = 1'b1;
    exp_iv1 = 0; exp_iv2 = 100000;
    do_reset();
    ref_en = 4'hF;
    run(40000, 0);
    drain();
    chk(rclk == ticks_now() / 100, "R5", rclk, ticks_now() / 100);
    chk(r2 == ticks_now() / 10000, "R6", r2, ticks_now() / 10000);
    chk(r1 == 0, "R7", r1, 0);

    // One second between pulse1 rises with a 100 us tick.
    tick_period = 20'd100000; prescale = 16'd7;
    period1 = 32'd999900000; period2 = 32'd249900000;
    exp_iv1 = 64'd1000000000; exp_iv2 = 64'd250000000;
    src_sel = 2'd2; src_sel_vld = 1'b1;
    do_reset();
    ref_en = 4'b0100;
    run(34000, 0);
    drain();
    chk(r1 == ticks_now() / 10000, "R7", r1, ticks_now() / 10000);
    chk(r2 == ticks_now() / 2500, "R6", r2, ticks_now() / 2500);
    chk(rclk == ticks_now() / 7, "R5", rclk, ticks_now() / 7);

    // Random sources, selects and addend trims with the pulses disabled.
    tick_period = 20'(($urandom % 1000) + 1);
    prescale = 16'(($urandom % 8) + 2);
    period1 = $urandom % 5000; period2 = $urandom % 5000;
    pulse_en = 1'b0; exp_iv1 = 0; exp_iv2 = 0;
    do_reset();
    run(20000, 1);
    drain();
    chk(hi_cnt == 0, "R8", hi_cnt, 0);
    chk(rclk == ticks_now() / prescale, "R5", rclk, ticks_now() / prescale);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule